// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes up to sixteen interrupt input lines to processors. Software sees only two 32-bit windows. The first window, the select register, holds an internal register index. The second window, the data window, reads or writes the register that the index names. Each input line has a 64-bit routing entry, split into two 32-bit halves at consecutive indices. An entry holds a vector number, a trigger mode, a mask, a destination mode, a delivery mode and an 8-bit destination.

The block samples the input lines on every clock. When a line goes from low to high and its entry permits delivery, the block emits a single-cycle request on one shared output. The request carries the vector, the destination, and a broadcast flag when the destination is all ones.

A masked, level-triggered line that rises is remembered as pending. When software later clears that mask, the block replays the request only if the line is still high; otherwise the pending request is dropped. Lines that become ready in the same cycle queue up and leave one per cycle, lowest line number first.

Top module: `irq_redirector`

## Requirements
- R1: A 32-bit write at byte offset 0x00 stores the whole 32-bit select value, and a 32-bit read at offset 0x00 returns that stored value; a data-window access at offset 0x10 acts on the index held in select bits 7:0.
- R2: Only accesses with `busBytes` = 4 at offset 0x00 or 0x10 have an effect; any other size or offset reads as zero, and a write to it changes no register.
- R3: Line p's entry sits at index 0x10+2p (bits 31:0) and 0x11+2p (bits 63:32); writing one half replaces only that half.
- R4: After reset every entry reads 0x00010000 in both halves (masked), and the ID register reads 0.
- R5: Index 0x00 is the ID register and keeps only written bits 27:24. Index 0x02 reads the ID value, and index 0x01 reads 0x00100011 (line count in bits 23:16). Writes to 0x01 and 0x02 are ignored, and unassigned indices read 0.
- R6: A request is raised only for a line seen low on one clock and high on the next; a line held high or falling raises nothing.
- R7: A rising line is delivered only if its entry has mask bit 16 = 0, destination-mode bit 11 = 0 and delivery-mode bits 10:8 = 000; the request carries entry bits 7:0 as the vector.
- R8: The request carries entry bits 63:56 on `dlvDestId`, and `dlvBroadcast` is 1 exactly when that field is 0xFF.
- R9: A rise on a line whose entry is masked with bit 15 = 1 (level) sets the line's pending flag and sends nothing; a rise on a masked edge-triggered entry is discarded.
- R10: A write that leaves a pending entry unmasked clears the pending flag. If the line is high, exactly one request goes out, judged with the newly written entry; if the line is low, nothing goes out.
- R11: `dlvValid` is high in the second clock after the edge that samples the rise (or the unmasking write). Requests waiting together leave one per cycle in ascending line order, each with the entry contents at the cycle it is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busBytes | input | 3 | Access size in bytes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| pinIn | input | 16 | Interrupt input lines, high = asserted |
| dlvValid | output | 1 | One-cycle delivery request |
| dlvVector | output | 8 | Vector of the request |
| dlvDestId | output | 8 | Destination field of the request |
| dlvBroadcast | output | 1 | Request targets all processors |

## Verification
The bench programs every line and raises it alone. It then checks the vector, destination, broadcast flag and cycle of the request, and confirms that holding the line high or dropping it sends nothing more. A design that fired on level rather than on edge would show extra requests here.

Eight lines rise together to check ascending, back-to-back service. A design with a broken queue would drop or reorder requests, or let them collide. The pending path is checked three ways: a replay after unmasking a line that is still high must carry the newly written vector; a second unmasking must not fire again; and a line that fell before the unmask must send nothing. A design that replayed stale state, or forgot to clear the pending flag, fails one of these.

Bad sizes and offsets, half-entry writes and the read-only indices are also checked, to catch decoding that leaks into neighbouring registers.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_BASE = 8'h10;
  localparam logic [31:0] ID_KEEP = 32'h0F00_0000;
  localparam logic [63:0] ENT_RESET = 64'h0001_0000_0001_0000;
  localparam int B_DESTMODE = 11;
  localparam int B_TRIG     = 15;
  localparam int B_MASK     = 16;

  // strobes from bus control to the datapath
  typedef struct packed {
    logic       winWr;   // data-window write this cycle
    logic       entHit;  // selected index falls inside the entry table
    logic [7:0] regIdx;  // selected register index
  } winStrobe_t;

  function automatic logic entCanFire(input logic [63:0] e);
    return !e[B_MASK] && !e[B_DESTMODE] && (e[10:8] == 3'b000);
  endfunction

  function automatic logic entParks(input logic [63:0] e);
    return e[B_MASK] && e[B_TRIG];
  endfunction
endpackage

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  logic       busWrite,
  input  logic [7:0] busAddr,
  input  logic [2:0] busBytes,
  input  logic [31:0] busWdata,
  input  logic [31:0] winData,
  output winStrobe_t stb,
  output logic [31:0] busRdata
);
  localparam int IDX_END = int'(IDX_BASE) + 2 * NUM_PINS;

  logic [31:0] selReg;
  logic goodSize, selHit, winHit;

  assign goodSize = busValid && (busBytes == 3'd4);
  assign selHit   = goodSize && (busAddr == OFF_SEL);
  assign winHit   = goodSize && (busAddr == OFF_WIN);

  assign stb.regIdx = selReg[7:0];
  assign stb.winWr  = winHit && busWrite;
  assign stb.entHit = (int'(selReg[7:0]) >= int'(IDX_BASE)) && (int'(selReg[7:0]) < IDX_END);

  always_comb begin
    busRdata = '0;
    if (selHit && !busWrite)      busRdata = selReg;
    else if (winHit && !busWrite) busRdata = winData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      selReg <= '0;
    else if (selHit && busWrite)    selReg <= busWdata;
  end
endmodule

// File: rtl/irq_redir_datapath.sv
module irq_redir_datapath
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  winStrobe_t          stb,
  input  logic [31:0]         wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [31:0]         rdData,
  output logic                waitAny,
  output logic                dlvValid,
  output logic [7:0]          dlvVector,
  output logic [7:0]          dlvDestId,
  output logic                dlvBroadcast
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [31:0] VERSION = (32'(NUM_PINS) << 16) | 32'h11;

  logic [NUM_PINS-1:0][63:0] ent, entNext;
  logic [NUM_PINS-1:0] pinPrev, pend, pendNext, waitQ, waitNext, req, grant;
  logic [31:0] idReg;
  logic [PIN_W-1:0] wrPin, gntIdx;

  assign wrPin = PIN_W'((stb.regIdx - IDX_BASE) >> 1);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit, rise, replay;
    assign hit  = stb.winWr && stb.entHit && (wrPin == PIN_W'(p));
    assign entNext[p] = !hit ? ent[p] :
                        (stb.regIdx[0] ? {wdata, ent[p][31:0]} : {ent[p][63:32], wdata});
    assign rise   = pinIn[p] && !pinPrev[p];
    assign replay = hit && pend[p] && !entNext[p][B_MASK];
    assign req[p] = (rise && entCanFire(ent[p])) ||
                    (replay && pinIn[p] && entCanFire(entNext[p]));
    assign pendNext[p] = replay ? 1'b0 : ((rise && entParks(ent[p])) ? 1'b1 : pend[p]);
    assign waitNext[p] = (waitQ[p] && !grant[p]) || req[p];
  end

  // lowest-numbered waiting line wins
  always_comb begin
    gntIdx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (waitQ[i]) gntIdx = PIN_W'(i);
  end
  assign waitAny = |waitQ;
  assign grant   = waitAny ? (NUM_PINS'(1) << gntIdx) : '0;

  always_comb begin
    rdData = '0;
    if (stb.entHit)
      rdData = stb.regIdx[0] ? ent[wrPin][63:32] : ent[wrPin][31:0];
    else if (stb.regIdx == IDX_ID || stb.regIdx == IDX_ARB)
      rdData = idReg;
    else if (stb.regIdx == IDX_VER)
      rdData = VERSION;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ent          <= {NUM_PINS{ENT_RESET}};
      pinPrev      <= '0;
      pend         <= '0;
      waitQ        <= '0;
      idReg        <= '0;
      dlvValid     <= 1'b0;
      dlvVector    <= '0;
      dlvDestId    <= '0;
      dlvBroadcast <= 1'b0;
    end else begin
      ent     <= entNext;
      pinPrev <= pinIn;
      pend    <= pendNext;
      waitQ   <= waitNext;
      if (stb.winWr && !stb.entHit && stb.regIdx == IDX_ID)
        idReg <= wdata & ID_KEEP;
      dlvValid     <= waitAny;
      dlvVector    <= ent[gntIdx][7:0];
      dlvDestId    <= ent[gntIdx][63:56];
      dlvBroadcast <= waitAny && (ent[gntIdx][63:56] == 8'hFF);
    end
  end
endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [7:0]          busAddr,
  input  logic [2:0]          busBytes,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                dlvValid,
  output logic [7:0]          dlvVector,
  output logic [7:0]          dlvDestId,
  output logic                dlvBroadcast
);
  winStrobe_t  stb;
  logic [31:0] winData;
  logic [7:0]  selIdx;
  logic        waitAny;

  assign selIdx = stb.regIdx;

  irq_redir_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busBytes(busBytes), .busWdata(busWdata),
    .winData(winData), .stb(stb), .busRdata(busRdata)
  );

  irq_redir_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .pinIn(pinIn),
    .rdData(winData), .waitAny(waitAny), .dlvValid(dlvValid),
    .dlvVector(dlvVector), .dlvDestId(dlvDestId), .dlvBroadcast(dlvBroadcast)
  );
endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int NUM_PINS = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [7:0]  busAddr,
  input logic [2:0]  busBytes,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [7:0]  selIdx,
  input logic        waitAny,
  input logic        dlvValid
);
  logic selRd, selWr, winRd;
  assign selWr = busValid && busWrite  && busBytes == 3'd4 && busAddr == 8'h00;
  assign selRd = busValid && !busWrite && busBytes == 3'd4 && busAddr == 8'h00;
  assign winRd = busValid && !busWrite && busBytes == 3'd4 && busAddr == 8'h10;

  a_r1_sel_readback: assert property (@(posedge clk) disable iff (!rstN)
    selWr |=> (!selRd || busRdata == $past(busWdata)));

  a_r2_bad_size_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busBytes != 3'd4) |-> busRdata == 32'h0);

  a_r2_bad_offset_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr != 8'h00 && busAddr != 8'h10) |-> busRdata == 32'h0);

  a_r5_version_const: assert property (@(posedge clk) disable iff (!rstN)
    (winRd && selIdx == 8'h01) |-> busRdata == ((32'(NUM_PINS) << 16) | 32'h11));

  a_r5_id_bits: assert property (@(posedge clk) disable iff (!rstN)
    (winRd && (selIdx == 8'h00 || selIdx == 8'h02)) |-> (busRdata & ~32'h0F00_0000) == 32'h0);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !waitAny |=> !dlvValid);
endmodule

bind irq_redirector irq_redir_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busBytes(busBytes), .busWdata(busWdata),
  .busRdata(busRdata), .selIdx(selIdx), .waitAny(waitAny), .dlvValid(dlvValid)
);

// File: tb/irq_redirector_test.sv
module irq_redirector_test;
  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0;
  logic [7:0] busAddr = 0;
  logic [2:0] busBytes = 3'd4;
  logic [31:0] busWdata = 0, busRdata;
  logic [15:0] pinIn = 0;
  logic dlvValid, dlvBroadcast;
  logic [7:0] dlvVector, dlvDestId;

  int tests = 0, fails = 0, cyc = 0, logN = 0;
  logic [7:0] logVec [0:255];
  logic [7:0] logDst [0:255];
  logic       logBc  [0:255];
  int         logCyc [0:255];

  irq_redirector uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busBytes(busBytes), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .dlvValid(dlvValid),
    .dlvVector(dlvVector), .dlvDestId(dlvDestId), .dlvBroadcast(dlvBroadcast)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rstN && dlvValid && logN < 256) begin
    logVec[logN] = dlvVector; logDst[logN] = dlvDestId;
    logBc[logN] = dlvBroadcast; logCyc[logN] = cyc; logN++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] n = 3'd4);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d; busBytes = n;
    @(negedge clk);
    busValid = 0; busWrite = 0; busBytes = 3'd4;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [2:0] n = 3'd4);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a; busBytes = n;
    #1 d = busRdata;
    busValid = 0; busBytes = 3'd4;
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [31:0] d);
    wr(8'h00, {24'h0, idx}); wr(8'h10, d);
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, {24'h0, idx}); rd(8'h10, d);
  endtask

  task automatic setPin(input int p, input logic v, output int t0);
    @(negedge clk); pinIn[p] = v; t0 = cyc;
  endtask

  task automatic expectNone(input string tag, input int k);
    int n0;
    n0 = logN;
    repeat (k) @(negedge clk);
    chk(tag, 64'(logN - n0), 64'd0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0, n0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R4 reset contents of every entry half
    for (int i = 0; i < 32; i++) begin
      rdReg(8'(8'h10 + i), d);
      chk($sformatf("R4 entry idx %0h", 8'h10 + i), 64'(d), 64'h0001_0000);
    end
    rdReg(8'h00, d); chk("R4 id reset", 64'(d), 64'h0);
    rdReg(8'h01, d); chk("R5 version", 64'(d), 64'h0010_0011);

    // R1 select readback
    wr(8'h00, 32'hA5C3_0F12);
    rd(8'h00, d); chk("R1 select readback", 64'(d), 64'hA5C3_0F12);

    // R5 id masking, arbitration mirror, read-only, unassigned
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdReg(8'h00, d); chk("R5 id keeps 27:24", 64'(d), 64'h0F00_0000);
    rdReg(8'h02, d); chk("R5 arb mirrors id", 64'(d), 64'h0F00_0000);
    wrReg(8'h01, 32'h0); rdReg(8'h01, d); chk("R5 version read-only", 64'(d), 64'h0010_0011);
    wrReg(8'h02, 32'h0); rdReg(8'h02, d); chk("R5 arb read-only", 64'(d), 64'h0F00_0000);
    rdReg(8'h03, d); chk("R5 unassigned idx 03", 64'(d), 64'h0);
    rdReg(8'h30, d); chk("R5 idx past table", 64'(d), 64'h0);

    // R2 bad sizes and offsets
    wr(8'h00, 32'h16);
    wr(8'h00, 32'h55, 3'd2);
    rd(8'h00, d); chk("R2 narrow select write ignored", 64'(d), 64'h16);
    rd(8'h00, d, 3'd1); chk("R2 narrow read zero", 64'(d), 64'h0);
    rd(8'h04, d); chk("R2 bad offset read zero", 64'(d), 64'h0);
    wr(8'h14, 32'hDEAD_BEEF);
    wr(8'h10, 32'hDEAD_BEEF, 3'd2);
    rd(8'h10, d); chk("R2 ignored writes leave entry", 64'(d), 64'h0001_0000);

    // R3 half writes
    wrReg(8'h16, 32'hAAAA_5555);
    rdReg(8'h16, d); chk("R3 low half written", 64'(d), 64'hAAAA_5555);
    rdReg(8'h17, d); chk("R3 high half kept", 64'(d), 64'h0001_0000);
    wrReg(8'h17, 32'h1234_5678);
    rdReg(8'h16, d); chk("R3 low half kept", 64'(d), 64'hAAAA_5555);
    rdReg(8'h17, d); chk("R3 high half written", 64'(d), 64'h1234_5678);

    // R6 R7 R8 R11 single-line sweep
    for (int p = 0; p < 16; p++) begin
      logic [7:0] dst;
      dst = (p == 5) ? 8'hFF : 8'(p + 1);
      wrReg(8'(8'h10 + 2 * p), 32'(8'h40 + p));
      wrReg(8'(8'h11 + 2 * p), {dst, 24'h0});
      n0 = logN;
      setPin(p, 1'b1, t0);
      repeat (4) @(negedge clk);
      chk($sformatf("R6 line %0d one request", p), 64'(logN - n0), 64'd1);
      chk($sformatf("R7 line %0d vector", p), 64'(logVec[n0]), 64'(8'h40 + p));
      chk($sformatf("R8 line %0d dest", p), 64'(logDst[n0]), 64'(dst));
      chk($sformatf("R8 line %0d broadcast", p), 64'(logBc[n0]), 64'(p == 5));
      chk($sformatf("R11 line %0d latency", p), 64'(logCyc[n0]), 64'(t0 + 2));
      expectNone("R6 held high", 3);
      setPin(p, 1'b0, t0);
      expectNone("R6 falling", 3);
    end

    // R11 simultaneous rises
    n0 = logN;
    @(negedge clk); pinIn = 16'hA5A5; t0 = cyc;
    repeat (12) @(negedge clk);
    chk("R11 eight requests", 64'(logN - n0), 64'd8);
    begin
      int k;
      k = 0;
      for (int p = 0; p < 16; p++) if (16'hA5A5 & (16'h1 << p)) begin
        chk($sformatf("R11 order slot %0d vector", k), 64'(logVec[n0 + k]), 64'(8'h40 + p));
        chk($sformatf("R11 order slot %0d cycle", k), 64'(logCyc[n0 + k]), 64'(t0 + 2 + k));
        k++;
      end
    end
    @(negedge clk); pinIn = 16'h0;
    repeat (3) @(negedge clk);

    // R7 blocked modes
    wrReg(8'h12, 32'h0000_0141);
    setPin(1, 1'b1, t0); expectNone("R7 non-fixed delivery", 4);
    wrReg(8'h14, 32'h0000_0842);
    setPin(2, 1'b1, t0); expectNone("R7 logical destination", 4);
    // R9 masked edge is discarded, unmask does not replay
    wrReg(8'h16, 32'h0001_0043);
    setPin(3, 1'b1, t0); expectNone("R9 masked edge", 4);
    wrReg(8'h16, 32'h0000_0043); expectNone("R9 edge no replay", 4);
    @(negedge clk); pinIn = 16'h0;

    // R9 R10 level pending and replay with the new entry
    wrReg(8'h18, 32'h0001_8044);
    setPin(4, 1'b1, t0); expectNone("R9 masked level parks", 4);
    n0 = logN;
    wrReg(8'h18, 32'h0000_8099);
    repeat (4) @(negedge clk);
    chk("R10 replay count", 64'(logN - n0), 64'd1);
    chk("R10 replay new vector", 64'(logVec[n0]), 64'h99);
    chk("R10 replay dest", 64'(logDst[n0]), 64'h05);
    wrReg(8'h18, 32'h0000_8099); expectNone("R10 pending cleared", 4);
    setPin(4, 1'b0, t0);

    // R10 dropped when line fell before unmask
    wrReg(8'h1C, 32'h0001_8066);
    setPin(6, 1'b1, t0); expectNone("R9 line 6 parks", 3);
    setPin(6, 1'b0, t0); expectNone("R6 line 6 fall", 3);
    wrReg(8'h1C, 32'h0000_8066); expectNone("R10 dropped when low", 4);
    n0 = logN;
    setPin(6, 1'b1, t0);
    repeat (4) @(negedge clk);
    chk("R10 fresh rise after drop", 64'(logN - n0), 64'd1);
    chk("R7 unmasked level vector", 64'(logVec[n0]), 64'h66);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule